// File: doc/BRIEF.md
# Serial Memory Byte-Address Tracker

This block holds the 16-bit byte address of a 64K-byte two-wire serial memory. A protocol engine (not part of this block) feeds it single-cycle strobes: a load strobe once both word-address bytes have arrived, a write-step strobe for each data byte accepted in a write, a read-step strobe for each byte sent out in a read, and a commit strobe when a stop condition ends a write. The block presents the current address, which a current-address read uses, and the slot index inside the 128-byte page buffer where the next written byte lands.

Write steps move only the in-page offset, so they wrap inside the page and later bytes overwrite earlier ones. Read steps move the full address and wrap from the top of the space to zero. On commit, a write of fewer than a full page leaves the address just past the last byte written, in the same page. A write of a full page or more puts the address back to the starting word address. A small state machine follows the write: ST_IDLE (no write open), ST_OPEN (address loaded, no data yet), ST_FILL (1 to 127 bytes taken) and ST_FULL (128 or more bytes taken). Its transitions are: T_LOAD from any state to ST_OPEN. T_FIRST from ST_OPEN to ST_FILL on the first data byte, or to ST_FULL when a page holds one byte. T_SAT from ST_FILL to ST_FULL on the 128th byte. T_COMMIT from any open state to ST_IDLE on commit. T_ABANDON from any open state to ST_IDLE on a read step.

Top module: `eep_addr_tracker`

## Requirements
- R1: After reset the current address is 0x0000 and the slot index is 0.
- R2: A load strobe puts its 16-bit value on the current address one cycle later and opens a write. The first received byte supplies bits 15..8 and the second supplies bits 7..0.
- R3: A write step in an open write adds one to bits 6..0 and wraps 127 to 0. Bits 15..7 stay unchanged. The slot index always equals bits 6..0 of the current address.
- R4: A read step adds one to the full 16-bit address. 0xFFFF is followed by 0x0000, and further steps continue from there.
- R5: A commit after 1 to 127 write steps leaves the start page with offset (start offset + count) mod 128.
- R6: A commit after 128 or more write steps restores the starting word address.
- R7: A single-byte write loaded at page offset 127 commits to offset 0 of the same page.
- R8: A write step or a commit with no open write has no effect on the address.
- R9: A load strobe takes priority over every other strobe in the same cycle. Those other strobes are dropped.
- R10: Within an open write, strobes in the same cycle are ranked commit, then write step, then read step. Only the highest-ranked one acts.
- R11: A read step during an open write closes that write. A later commit then has no effect on the address.
- R12: A commit directly after a load, with no data bytes, leaves the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Strobe: load the assembled word address |
| load_addr_i | input | 16 | Word address (bits 15..8 from the first byte, 7..0 from the second) |
| wr_inc_i | input | 1 | Strobe: one data byte accepted in a write |
| rd_inc_i | input | 1 | Strobe: one data byte sent in a read |
| wr_commit_i | input | 1 | Strobe: stop condition ended the write |
| cur_addr_o | output | 16 | Current byte address |
| slot_o | output | 7 | Page-buffer slot index (offset in page) |

## Verification
Several strobes can meet in one cycle. A load can arrive together with a step or commit strobe. Inside an open write, a commit can coincide with a final data byte, and a write step can coincide with a read step. The bench drives these pairs in a single cycle and compares the next address with the one the ranking predicts: the load value, the commit result without the extra byte, or a page-only step with the write still open. The last case is confirmed by a later commit that still restores or keeps the page offset.

// File: rtl/eeac_pkg.sv
package eeac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPEN = 2'd1,
        ST_FILL = 2'd2,
        ST_FULL = 2'd3
    } wr_state_e;

endpackage

// File: rtl/eeac_fill_cnt.sv
module eeac_fill_cnt #(
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              inc_i,
    output logic [PAGE_W:0]   cnt_o,
    output logic              last_slot_o
);
    localparam int CNT_W      = PAGE_W + 1;
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && (cnt_q != CNT_W'(PAGE_BYTES))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        cnt_o       = cnt_q;
        last_slot_o = (cnt_q == CNT_W'(PAGE_BYTES - 1));
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(PAGE_BYTES)); // R6

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_q == '0); // R2

endmodule

// File: rtl/eeac_wr_fsm.sv
module eeac_wr_fsm
    import eeac_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_i,
    input  logic      commit_i,
    input  logic      wr_inc_i,
    input  logic      rd_inc_i,
    input  logic      last_slot_i,
    output logic      load_en_o,
    output logic      commit_en_o,
    output logic      wr_en_o,
    output logic      rd_en_o,
    output logic      restore_o,
    output wr_state_e state_o
);
    wr_state_e state_q;
    wr_state_e state_d;
    logic      open_w;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs: strobe ranking load > commit > write step > read step
    always_comb begin
        open_w      = (state_q != ST_IDLE);
        load_en_o   = load_i;
        commit_en_o = !load_i && commit_i && open_w;
        wr_en_o     = !load_i && !(commit_i && open_w) && wr_inc_i && open_w;
        rd_en_o     = !load_i && !(commit_i && open_w) && !(wr_inc_i && open_w) && rd_inc_i;
        restore_o   = commit_en_o && (state_q == ST_FULL);
        state_o     = state_q;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (load_en_o) begin
            state_d = ST_OPEN;                                   // T_LOAD
        end else if (commit_en_o || rd_en_o) begin
            state_d = ST_IDLE;                                   // T_COMMIT / T_ABANDON
        end else if (wr_en_o) begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_OPEN: state_d = last_slot_i ? ST_FULL : ST_FILL; // T_FIRST
                ST_FILL: state_d = last_slot_i ? ST_FULL : ST_FILL; // T_SAT
                ST_FULL: state_d = ST_FULL;
            endcase
        end
    end

    AST_LOAD_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> state_q == ST_OPEN); // R2

    AST_ABANDON_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_inc_i && !load_i && !commit_i && !wr_inc_i) |=> state_q == ST_IDLE); // R11

endmodule

// File: rtl/eeac_addr_path.sv
module eeac_addr_path #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic              restore_i,
    output logic [ADDR_W-1:0] cur_o,
    output logic [PAGE_W-1:0] slot_o
);
    localparam int PAGE_HI_W = ADDR_W - PAGE_W;

    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] start_q;
    logic [PAGE_W-1:0] offs_next;

    always_comb begin
        offs_next = cur_q[PAGE_W-1:0] + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q   <= '0;
            start_q <= '0;
        end else if (load_en_i) begin
            cur_q   <= load_addr_i;
            start_q <= load_addr_i;
        end else if (restore_i) begin
            cur_q   <= start_q;
        end else if (wr_en_i) begin
            cur_q   <= {cur_q[ADDR_W-1:PAGE_W], offs_next};
        end else if (rd_en_i) begin
            cur_q   <= cur_q + 1'b1;
        end
    end

    always_comb begin
        cur_o  = cur_q;
        slot_o = cur_q[PAGE_W-1:0];
    end

    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> cur_q[ADDR_W-1:PAGE_W] == $past(cur_q[ADDR_W-1:PAGE_W])); // R3

    AST_PAGE_HI_W: assert property (@(posedge clk) disable iff (!rst_n)
        restore_i |=> cur_q[ADDR_W-1:PAGE_W] == PAGE_HI_W'($past(start_q) >> PAGE_W)); // R6

endmodule

// File: rtl/eep_addr_tracker.sv
module eep_addr_tracker
    import eeac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              wr_inc_i,
    input  logic              rd_inc_i,
    input  logic              wr_commit_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [PAGE_W-1:0] slot_o
);
    localparam int CNT_W      = PAGE_W + 1;
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic             load_en;
    logic             commit_en;
    logic             wr_en;
    logic             rd_en;
    logic             restore;
    logic             last_slot;
    logic [CNT_W-1:0] fill_cnt;
    wr_state_e        wr_state;

    eeac_wr_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .commit_i    (wr_commit_i),
        .wr_inc_i    (wr_inc_i),
        .rd_inc_i    (rd_inc_i),
        .last_slot_i (last_slot),
        .load_en_o   (load_en),
        .commit_en_o (commit_en),
        .wr_en_o     (wr_en),
        .rd_en_o     (rd_en),
        .restore_o   (restore),
        .state_o     (wr_state)
    );

    eeac_fill_cnt #(.PAGE_W(PAGE_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (load_en),
        .inc_i       (wr_en),
        .cnt_o       (fill_cnt),
        .last_slot_o (last_slot)
    );

    eeac_addr_path #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en_i   (load_en),
        .load_addr_i (load_addr_i),
        .wr_en_i     (wr_en),
        .rd_en_i     (rd_en),
        .restore_i   (restore),
        .cur_o       (cur_addr_o),
        .slot_o      (slot_o)
    );

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cur_addr_o == $past(load_addr_i)); // R9

    AST_RD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_inc_i && !load_i && !wr_inc_i && !wr_commit_i && (cur_addr_o == '1)) |=> cur_addr_o == '0); // R4

    AST_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_state == ST_FULL) |-> fill_cnt == CNT_W'(PAGE_BYTES)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_state == ST_IDLE) && !load_i && !rd_inc_i) |=> $stable(cur_addr_o)); // R8

    AST_COMMIT_BEATS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && wr_inc_i && (wr_state == ST_FILL)) |=> $stable(cur_addr_o)); // R10

endmodule

// File: tb/sim_eep_addr_tracker.sv
module sim_eep_addr_tracker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        load_i;
    logic [15:0] load_addr_i;
    logic        wr_inc_i;
    logic        rd_inc_i;
    logic        wr_commit_i;
    logic [15:0] cur_addr_o;
    logic [6:0]  slot_o;

    always #4 clk = ~clk;

    eep_addr_tracker u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .load_addr_i (load_addr_i),
        .wr_inc_i    (wr_inc_i),
        .rd_inc_i    (rd_inc_i),
        .wr_commit_i (wr_commit_i),
        .cur_addr_o  (cur_addr_o),
        .slot_o      (slot_o)
    );

    typedef struct {
        logic [15:0] addr;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    // reference state built from the requirements
    logic [15:0] m_cur   = 16'h0000;
    logic [15:0] m_start = 16'h0000;
    int          m_cnt   = 0;
    bit          m_open  = 0;

    task automatic step(input logic ld, input logic [15:0] la, input logic wi,
                        input logic ri, input logic cm, input string tag);
        exp_t e;
        @(negedge clk);
        load_i = ld; load_addr_i = la; wr_inc_i = wi; rd_inc_i = ri; wr_commit_i = cm;
        @(posedge clk);
        if (ld) begin
            m_cur = la; m_start = la; m_cnt = 0; m_open = 1;
        end else if (cm && m_open) begin
            if (m_cnt >= 128) m_cur = m_start;
            m_open = 0;
        end else if (wi && m_open) begin
            m_cur[6:0] = m_cur[6:0] + 7'd1;
            if (m_cnt < 128) m_cnt++;
        end else if (ri) begin
            m_cur = m_cur + 16'd1;
            m_open = 0;
        end
        e.addr = m_cur; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic quiet();
        @(negedge clk);
        load_i = 0; wr_inc_i = 0; rd_inc_i = 0; wr_commit_i = 0;
    endtask

    task automatic bytes(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 16'h0, 1, 0, 0, tag);
    endtask

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (cur_addr_o !== e.addr || slot_o !== e.addr[6:0]) begin
                    errors++;
                    $display("FAIL %s: addr %h slot %0d, expected addr %h slot %0d",
                             e.tag, cur_addr_o, slot_o, e.addr, e.addr[6:0]);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_t e;
        rst_n = 0; load_i = 0; load_addr_i = 0; wr_inc_i = 0; rd_inc_i = 0; wr_commit_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        e.addr = 16'h0000; e.tag = "R1 reset state";
        q.push_back(e);

        // R2 load, R5 short page write
        step(1, 16'h1234, 0, 0, 0, "R2 load");
        bytes(3, "R3 page step");
        step(0, 0, 0, 0, 1, "R5 commit after 3 bytes");

        // R3 in-page wrap, R5 commit across the wrap
        step(1, 16'h12FE, 0, 0, 0, "R2 load near page end");
        bytes(3, "R3 wrap inside page");
        step(0, 0, 0, 0, 1, "R5 commit after wrap");

        // R7 byte write at offset 127
        step(1, 16'h00FF, 0, 0, 0, "R2 load offset 127");
        bytes(1, "R7 single byte");
        step(0, 0, 0, 0, 1, "R7 commit to offset 0");

        // R6 exactly a page, then more than a page
        step(1, 16'h4010, 0, 0, 0, "R2 load");
        bytes(128, "R3 full page");
        step(0, 0, 0, 0, 1, "R6 commit after 128");
        step(1, 16'h4010, 0, 0, 0, "R2 load");
        bytes(130, "R3 over page");
        step(0, 0, 0, 0, 1, "R6 commit after 130");

        // R4 read across top of space
        step(1, 16'hFFFE, 0, 0, 0, "R2 dummy write load");
        step(0, 0, 0, 1, 0, "R4 read step");
        step(0, 0, 0, 1, 0, "R4 read wrap to zero");
        step(0, 0, 0, 1, 0, "R4 read continues");

        // R8 no open write
        step(0, 0, 1, 0, 0, "R8 write step ignored");
        step(0, 0, 0, 0, 1, "R8 commit ignored");

        // R9 load with every other strobe
        step(1, 16'hA5C3, 1, 1, 1, "R9 load wins");

        // R10 commit vs byte, byte vs read
        step(1, 16'h2000, 0, 0, 0, "R2 load");
        bytes(2, "R3 two bytes");
        step(0, 0, 1, 0, 1, "R10 commit drops byte");
        step(1, 16'h6000, 0, 0, 0, "R2 load");
        bytes(127, "R3 fill page");
        step(0, 0, 1, 1, 0, "R10 byte beats read");
        step(0, 0, 0, 0, 1, "R10 write still open, restore");

        // R11 read step abandons write
        step(1, 16'h5000, 0, 0, 0, "R2 load");
        bytes(130, "R3 over page");
        step(0, 0, 0, 1, 0, "R11 read step in write");
        step(0, 0, 0, 0, 1, "R11 commit no effect");

        // R12 zero-byte write
        step(1, 16'h7777, 0, 0, 0, "R2 load");
        step(0, 0, 0, 0, 1, "R12 commit after load");

        quiet();
        repeat (3) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule